// File: doc/BRIEF.md
# Partial Flag Validity Qualifier

This block sits beside a dual-clock FIFO and decides when its almost-full and almost-empty indications may be trusted. The comparisons are computed elsewhere and arrive here raw, the almost-full result in the write clock domain and the almost-empty result in the read clock domain. The offset unit reports two things on the write clock: the start of a programming session, and the completion of each offset word. From these reports the block keeps a record, per word, of whether that word holds a usable threshold.

Each flag becomes eligible when the words it depends on are recorded. In parallel mode a flag depends only on its own word. In serial mode both flags wait for both words. Eligibility then passes through a fixed number of clock edges before the matching valid output rises. The almost-full side counts write edges. The almost-empty side crosses into the read domain through a two-stage synchronizer. Each qualified flag is the raw comparison masked by its valid bit, so an unqualified flag always reads inactive.

Top module: `pflag_qualifier`

## Requirements
- R1: `mrst` or `prst` high clears `af_vld` and `ae_vld` at once, without waiting for a clock edge. Master reset marks both offset words as recorded, because default thresholds are loaded. Partial reset leaves the word record as it was.
- R2: After reset is released, with the needed words recorded, `af_vld` rises at the second `wr_clk` rising edge and `ae_vld` at the second `rd_clk` rising edge.
- R3: A `prog_start` pulse sampled at a write edge P erases the word record. `af_vld` is low from edge P itself. `ae_vld` falls at the second read edge after P.
- R4: In parallel mode (`ser_mode`=0), a recorded almost-full word (`word_wr` with `word_sel`=1) qualifies only the almost-full flag. A recorded almost-empty word (`word_sel`=0) qualifies only the almost-empty flag.
- R5: In serial mode (`ser_mode`=1), neither flag is eligible until both words have been recorded since the last `prog_start`.
- R6: `af_vld` rises at the second `wr_clk` rising edge after the write edge that makes the almost-full flag eligible. It is still low after the first of those edges.
- R7: `ae_vld` rises at the second `rd_clk` rising edge after the write edge that makes the almost-empty flag eligible. It is still low after the first of those edges.
- R8: While `rd_clk` is stopped, `ae_vld` holds its value. After the clock restarts, a pending change appears at the second read rising edge.
- R9: `af_flag` equals `af_raw` AND `af_vld`. `ae_flag` equals `ae_raw` AND `ae_vld`. Both flags are active-high, so an unqualified flag reads 0.
- R10: A word completion reported in the same write edge as `prog_start` is recorded as part of the new session.
- R11: Idle write cycles between `prog_start` and the word completions, in either mode, do not change the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, asynchronous |
| prst | input | 1 | Partial reset, active high, asynchronous |
| ser_mode | input | 1 | 1 = serial offset loading, 0 = parallel |
| prog_start | input | 1 | Programming session begins (write domain pulse) |
| word_wr | input | 1 | An offset word has been completed (write domain pulse) |
| word_sel | input | 1 | Word completed: 0 almost-empty offset, 1 almost-full offset |
| af_raw | input | 1 | Unqualified almost-full comparison (write domain) |
| ae_raw | input | 1 | Unqualified almost-empty comparison (read domain) |
| af_vld | output | 1 | Almost-full indication is valid |
| ae_vld | output | 1 | Almost-empty indication is valid |
| af_flag | output | 1 | Qualified almost-full flag |
| ae_flag | output | 1 | Qualified almost-empty flag |

## Verification
The bench counts edges exactly on both sides, using clocks that never share an edge. A pipeline one stage too short or too long therefore shows up as a valid bit that rises one edge early or late.

Several cases target specific faults:
- Serial sessions complete one word and then wait. A design that applied the parallel rule would validate a flag too early.
- Partial reset is applied between two words of a parallel session. A design that wiped the word record would never revalidate the almost-empty side, and one that ignored the reset would keep `ae_vld` high.
- The read clock is halted while eligibility falls, and `ae_vld` is counted again after restart.
- A start that coincides with a word completion is included. A design that drops that word would leave `af_vld` low.

// File: rtl/pfq_pkg.sv
`timescale 1ns/100ps
package pfq_pkg;

    // Which offset word a completion report refers to
    typedef enum logic {
        WORD_EMPTY = 1'b0,
        WORD_FULL  = 1'b1
    } pfq_word_e;

    // Write-domain record of programmed words and derived eligibility
    typedef struct packed {
        logic mark_e;
        logic mark_f;
        logic elig_ae;
        logic elig_af;
    } pfq_track_t;

    // Defaults are loaded by master reset, so both words count as present
    localparam pfq_track_t TRACK_RESET = '{mark_e: 1'b1, mark_f: 1'b1,
                                           elig_ae: 1'b1, elig_af: 1'b1};

endpackage

// File: rtl/pfq_word_track.sv
`timescale 1ns/100ps
module pfq_word_track
    import pfq_pkg::*;
(
    input  logic wr_clk,
    input  logic mrst,
    input  logic ser_mode,
    input  logic prog_start,
    input  logic word_wr,
    input  logic word_sel,
    output logic elig_af,
    output logic elig_ae
);

    pfq_track_t st_d, st_q;

    always_comb begin
        logic keep;
        logic both;
        st_d = st_q;
        keep = ~prog_start;
        // a session start wipes the record; a word reported in the same edge still counts
        st_d.mark_e = (st_q.mark_e & keep) |
                      (word_wr & (pfq_word_e'(word_sel) == WORD_EMPTY));
        st_d.mark_f = (st_q.mark_f & keep) |
                      (word_wr & (pfq_word_e'(word_sel) == WORD_FULL));
        both = st_d.mark_e & st_d.mark_f;
        st_d.elig_ae = ser_mode ? both : st_d.mark_e;
        st_d.elig_af = ser_mode ? both : st_d.mark_f;
    end

    always_ff @(posedge wr_clk or posedge mrst) begin
        if (mrst) begin
            st_q <= TRACK_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign elig_af = st_q.elig_af;
    assign elig_ae = st_q.elig_ae;

endmodule

// File: rtl/pfq_stage_pipe.sv
`timescale 1ns/100ps
module pfq_stage_pipe #(
    parameter int STAGES     = 2,
    parameter bit EARLY_DROP = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic din,
    output logic dout
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] pipe_d, pipe_q;

    generate
        if (EARLY_DROP) begin : g_early
            // same-domain input: every stage also needs the input still high,
            // so a falling input withdraws the output in the same edge
            always_comb begin
                pipe_d[0] = din & ~clr;
                for (int i = 1; i < STAGES; i++) begin
                    pipe_d[i] = pipe_q[i-1] & din & ~clr;
                end
            end
        end else begin : g_sync
            // foreign-domain input: plain shift chain, input touches stage 0 only
            always_comb begin
                pipe_d[0] = din & ~clr;
                for (int i = 1; i < STAGES; i++) begin
                    pipe_d[i] = pipe_q[i-1] & ~clr;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[LAST];

endmodule

// File: rtl/pflag_qualifier.sv
`timescale 1ns/100ps
module pflag_qualifier #(
    parameter int WR_STAGES   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic wr_clk,
    input  logic rd_clk,
    input  logic mrst,
    input  logic prst,
    input  logic ser_mode,
    input  logic prog_start,
    input  logic word_wr,
    input  logic word_sel,
    input  logic af_raw,
    input  logic ae_raw,
    output logic af_vld,
    output logic ae_vld,
    output logic af_flag,
    output logic ae_flag
);

    logic rst_any;
    logic elig_af;
    logic elig_ae;

    assign rst_any = mrst | prst;

    pfq_word_track u_track (
        .wr_clk     (wr_clk),
        .mrst       (mrst),
        .ser_mode   (ser_mode),
        .prog_start (prog_start),
        .word_wr    (word_wr),
        .word_sel   (word_sel),
        .elig_af    (elig_af),
        .elig_ae    (elig_ae)
    );

    pfq_stage_pipe #(.STAGES(WR_STAGES), .EARLY_DROP(1'b1)) u_af_pipe (
        .clk  (wr_clk),
        .rst  (rst_any),
        .clr  (prog_start),
        .din  (elig_af),
        .dout (af_vld)
    );

    pfq_stage_pipe #(.STAGES(SYNC_STAGES), .EARLY_DROP(1'b0)) u_ae_sync (
        .clk  (rd_clk),
        .rst  (rst_any),
        .clr  (1'b0),
        .din  (elig_ae),
        .dout (ae_vld)
    );

    assign af_flag = af_raw & af_vld;
    assign ae_flag = ae_raw & ae_vld;

endmodule

// File: rtl/pfq_checker.sv
`timescale 1ns/100ps
module pfq_checker (
    input logic wr_clk,
    input logic rd_clk,
    input logic mrst,
    input logic prst,
    input logic ser_mode,
    input logic prog_start,
    input logic elig_af,
    input logic elig_ae,
    input logic af_vld,
    input logic ae_vld,
    input logic af_flag,
    input logic ae_flag
);

    // R9
    af_gate_chk: assert property (@(posedge wr_clk) disable iff (mrst || prst)
        !af_vld |-> !af_flag);

    // R9
    ae_gate_chk: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        !ae_vld |-> !ae_flag);

    // R3
    af_drop_chk: assert property (@(posedge wr_clk) disable iff (mrst || prst)
        prog_start |=> !af_vld);

    // R6
    af_rise_chk: assert property (@(posedge wr_clk) disable iff (mrst || prst)
        $rose(af_vld) |-> (elig_af && $past(elig_af)));

    // R7
    ae_rise_chk: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        $rose(ae_vld) |-> $past(elig_ae));

    // R5
    ser_pair_chk: assert property (@(posedge wr_clk) disable iff (mrst || prst)
        (ser_mode && af_vld) |-> elig_ae);

endmodule

bind pflag_qualifier pfq_checker i_pfq_checker (
    .wr_clk     (wr_clk),
    .rd_clk     (rd_clk),
    .mrst       (mrst),
    .prst       (prst),
    .ser_mode   (ser_mode),
    .prog_start (prog_start),
    .elig_af    (elig_af),
    .elig_ae    (elig_ae),
    .af_vld     (af_vld),
    .ae_vld     (ae_vld),
    .af_flag    (af_flag),
    .ae_flag    (ae_flag)
);

// File: tb/test_pflag_qualifier.sv
`timescale 1ns/100ps
module test_pflag_qualifier;

    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    logic rd_run = 1'b1;
    logic mrst = 1'b1;
    logic prst = 1'b0;
    logic ser_mode = 1'b0;
    logic prog_start = 1'b0;
    logic word_wr = 1'b0;
    logic word_sel = 1'b0;
    logic af_raw = 1'b0;
    logic ae_raw = 1'b0;
    logic af_vld, ae_vld, af_flag, ae_flag;

    int total = 0;
    int bad = 0;

    // vector: [7] ser_mode, [6] first word_sel, [5:2] idle gap,
    //         [1] expected af_vld after first word, [0] expected ae_vld after first word
    localparam logic [7:0] VEC [5] = '{
        8'b0_0_0000_0_1,
        8'b0_1_0011_1_0,
        8'b1_0_0101_0_0,
        8'b1_1_0000_0_0,
        8'b0_0_0111_0_1
    };

    pflag_qualifier i_pflag_qualifier (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst),
        .ser_mode(ser_mode), .prog_start(prog_start), .word_wr(word_wr),
        .word_sel(word_sel), .af_raw(af_raw), .ae_raw(ae_raw),
        .af_vld(af_vld), .ae_vld(ae_vld), .af_flag(af_flag), .ae_flag(ae_flag)
    );

    // 125 MHz write clock; read clock 13 ns on half-ns edges, never coincident
    always #4 wr_clk = ~wr_clk;
    initial begin
        #0.5;
        forever begin
            if (rd_run) rd_clk = ~rd_clk;
            #6.5;
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic wait_wr(input int n);
        repeat (n) @(negedge wr_clk);
    endtask

    task automatic pulse_start();
        @(negedge wr_clk); prog_start = 1'b1;
        @(negedge wr_clk); prog_start = 1'b0;
    endtask

    task automatic pulse_word(input logic sel);
        @(negedge wr_clk); word_wr = 1'b1; word_sel = sel;
        @(negedge wr_clk); word_wr = 1'b0;
    endtask

    // drive one event at write edge E, then count edges on both sides
    task automatic timed(input logic do_start, input logic do_word, input logic sel,
                         input logic [2:0] afx, input logic [1:0] aex,
                         input string taf, input string tae);
        @(negedge wr_clk);
        prog_start = do_start; word_wr = do_word; word_sel = sel;
        fork
            begin
                @(negedge wr_clk); prog_start = 1'b0; word_wr = 1'b0;
                chk(af_vld, afx[2], taf);
                @(negedge wr_clk); chk(af_vld, afx[1], taf);
                @(negedge wr_clk); chk(af_vld, afx[0], taf);
            end
            begin
                @(posedge wr_clk);
                @(posedge rd_clk); #1 chk(ae_vld, aex[1], tae);
                @(posedge rd_clk); #1 chk(ae_vld, aex[0], tae);
            end
        join
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1, R9: reset state with raw comparisons active
        af_raw = 1'b1; ae_raw = 1'b1;
        wait_wr(3);
        chk(af_vld, 1'b0, "R1 af_vld in reset");
        chk(ae_vld, 1'b0, "R1 ae_vld in reset");
        chk(af_flag, 1'b0, "R9 af_flag in reset");
        chk(ae_flag, 1'b0, "R9 ae_flag in reset");

        // R2: release and count edges on both sides
        fork
            begin
                @(negedge wr_clk); mrst = 1'b0;
                @(negedge wr_clk); chk(af_vld, 1'b0, "R2 af first edge");
                @(negedge wr_clk); chk(af_vld, 1'b1, "R2 af second edge");
            end
            begin
                @(negedge wr_clk);
                @(posedge rd_clk); #1 chk(ae_vld, 1'b0, "R2 ae first edge");
                @(posedge rd_clk); #1 chk(ae_vld, 1'b1, "R2 ae second edge");
            end
        join
        wait_wr(1);
        chk(af_flag, 1'b1, "R9 af_flag passes raw");
        chk(ae_flag, 1'b1, "R9 ae_flag passes raw");
        af_raw = 1'b0; #1;
        chk(af_flag, 1'b0, "R9 af_flag follows raw low");
        af_raw = 1'b1;

        // parallel mode: R3 drop, then R4 / R6 / R7 word by word
        timed(1'b1, 1'b0, 1'b0, 3'b000, 2'b10, "R3 af drop", "R3 ae drop");
        chk(af_flag, 1'b0, "R9 af_flag masked");
        timed(1'b0, 1'b1, 1'b0, 3'b000, 2'b01, "R4 af untouched by empty word", "R7 ae rise");
        timed(1'b0, 1'b1, 1'b1, 3'b001, 2'b11, "R6 af rise", "R4 ae unaffected");

        // serial mode: R5
        @(negedge wr_clk); ser_mode = 1'b1;
        timed(1'b1, 1'b0, 1'b0, 3'b000, 2'b10, "R3 af drop serial", "R3 ae drop serial");
        timed(1'b0, 1'b1, 1'b0, 3'b000, 2'b00, "R5 af waits", "R5 ae waits");
        wait_wr(6);
        chk(ae_vld, 1'b0, "R5 ae still waiting");
        timed(1'b0, 1'b1, 1'b1, 3'b001, 2'b01, "R6 af rise serial", "R7 ae rise serial");

        // R10: start and full word in the same edge, parallel mode
        @(negedge wr_clk); ser_mode = 1'b0;
        timed(1'b1, 1'b1, 1'b1, 3'b001, 2'b10, "R10 af counted", "R3 ae drop");
        wait_wr(8);
        chk(ae_vld, 1'b0, "R10 empty word erased");
        pulse_word(1'b0);
        wait_wr(8);
        chk(ae_vld, 1'b1, "R4 ae after empty word");

        // R8: read clock halted
        @(posedge rd_clk); rd_run = 1'b0;
        pulse_start();
        wait_wr(20);
        chk(ae_vld, 1'b1, "R8 ae held while rd stopped");
        chk(af_vld, 1'b0, "R3 af low after start");
        rd_run = 1'b1;
        @(posedge rd_clk); #1 chk(ae_vld, 1'b1, "R8 ae first edge after restart");
        @(posedge rd_clk); #1 chk(ae_vld, 1'b0, "R8 ae second edge after restart");
        pulse_word(1'b0);
        pulse_word(1'b1);
        wait_wr(8);

        // R1: partial reset keeps the word record
        pulse_start();
        pulse_word(1'b0);
        wait_wr(8);
        chk(ae_vld, 1'b1, "R4 ae before partial reset");
        chk(af_vld, 1'b0, "R4 af before partial reset");
        @(negedge wr_clk); prst = 1'b1; #1;
        chk(ae_vld, 1'b0, "R1 ae cleared by partial reset");
        wait_wr(3); prst = 1'b0;
        wait_wr(8);
        chk(ae_vld, 1'b1, "R1 ae back after partial reset");
        chk(af_vld, 1'b0, "R1 af record kept after partial reset");
        @(negedge wr_clk); mrst = 1'b1;
        wait_wr(2); mrst = 1'b0;
        wait_wr(8);
        chk(af_vld, 1'b1, "R1 af after master reset");
        chk(ae_vld, 1'b1, "R1 ae after master reset");

        // R11: table of sessions with idle gaps
        for (int i = 0; i < 5; i++) begin
            logic [7:0] v;
            v = VEC[i];
            @(negedge wr_clk); ser_mode = v[7];
            pulse_start();
            wait_wr(int'(v[5:2]));
            pulse_word(v[6]);
            wait_wr(8);
            chk(af_vld, v[1], v[7] ? "R5 af after first word" : "R4 af after first word");
            chk(ae_vld, v[0], v[7] ? "R5 ae after first word" : "R4 ae after first word");
            wait_wr(int'(v[5:2]));
            pulse_word(~v[6]);
            wait_wr(8);
            chk(af_vld, 1'b1, "R11 af after both words");
            chk(ae_vld, 1'b1, "R11 ae after both words");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule